// File: doc/BRIEF.md
# Multi-Mode PWM Channel Generator

This block produces one pulse-width-modulated output from a clock that serves as a 10 ns tick. It has four operating schemes, and a mode register selects one of them. Off holds the pin low. Standard mode uses a fixed 256-tick frame with an 8-bit duty. Fast mode spreads the same 8-bit duty as single-tick pulses across the frame. Variable-frequency mode alternates a low phase and a high phase, and each phase length comes from its own 13-bit register.

Software writes four small registers through a single-cycle write strobe. Duty and period writes go to pending copies. The generator adopts those copies only at the end of its current period, so a write never cuts or stretches a pulse that is already under way. A write that gives the mode register a new value restarts the channel at once. Each scheme restarts from the beginning of its period, and the variable-frequency scheme always restarts with its low phase.

Top module: `pwm_channel`

## Requirements
- R1: A synchronous active-high reset drives the output low, selects off mode and clears the pending duty and both pending period values to 0, so that entering standard mode straight after reset gives no high ticks.
- R2: In off mode (mode code 0) the output stays low. Writes to the duty or period registers do not change it.
- R3: Register addresses on `wr_addr` are as follows. Address 0 is the mode, held in `wr_data[1:0]` (0 off, 1 standard, 2 fast, 3 variable frequency). Address 1 is the duty, held in `wr_data[7:0]`. Address 2 is the low-phase length and address 3 is the high-phase length, each held in `wr_data[12:0]`.
- R4: Standard mode (code 1) repeats a 256-tick frame. The output is high for the first `duty` ticks of the frame and low for the rest, so duty 255 gives 255 high ticks out of 256 and duty 0 gives none.
- R5: In fast mode (code 2) with duty below 128, each 256-tick frame holds exactly `duty` high ticks and no two of them are adjacent. Duty 0 gives a constant low output.
- R6: In fast mode with duty 128 or more, each 256-tick frame holds exactly 255−`duty` low ticks and no two of them are adjacent. This gives `duty`+1 high ticks, and duty 255 gives a constant high output.
- R7: Variable-frequency mode (code 3) repeats a low phase of `lo`+1 ticks followed by a high phase of `hi`+1 ticks, with each value in the range 0..8191.
- R8: A new duty value takes effect at the first tick of the next 256-tick frame. This includes a write made in the last tick of a frame, which applies to the frame that immediately follows.
- R9: New low or high period values take effect only after the current high phase ends, which means at the start of the next full period.
- R10: A mode write with a value different from the current mode restarts the channel on the next tick. The channel adopts the pending duty and period values, starts its frame from the beginning, and begins variable-frequency mode with the low phase.
- R11: A mode write that repeats the current mode value has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz tick clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register select (0 mode, 1 duty, 2 low period, 3 high period) |
| wr_data | input | 13 | Write value; each register takes its low bits |
| pwm_out | output | 1 | PWM output pin |

## Verification
Two events can land in the same cycle: a software write, and the period boundary at which pending values are adopted. The bench provokes this by writing the duty in the last tick of a standard frame. It passes only if the new duty shapes the very next frame, with no frame skipped. The bench also writes phase lengths in the middle of a high phase and changes mode in the middle of a frame. The measured run lengths have to show that the running period is left untouched in the first case and that the restart takes effect on the following tick in the second.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_STD  = 2'd1,
    PM_FAST = 2'd2,
    PM_VAR  = 2'd3
  } pwm_mode_e;

  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_DUTY = 2'd1;
  localparam logic [1:0] REG_LO   = 2'd2;
  localparam logic [1:0] REG_HI   = 2'd3;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int PER_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [PER_W-1:0]  wr_data,
  output pwm_mode_e         mode_q,
  output logic              restart,
  output logic [DUTY_W-1:0] duty_nxt,
  output logic [PER_W-1:0]  lo_nxt,
  output logic [PER_W-1:0]  hi_nxt
);

  logic [DUTY_W-1:0] duty_pend;
  logic [PER_W-1:0]  lo_pend, hi_pend;
  pwm_mode_e         mode_wr;

  assign mode_wr = pwm_mode_e'(wr_data[1:0]);
  assign restart = wr_en && (wr_addr == REG_MODE) && (mode_wr != mode_q);

  // pending values as they stand after this cycle's write (forwarded)
  assign duty_nxt = (wr_en && wr_addr == REG_DUTY) ? wr_data[DUTY_W-1:0] : duty_pend;
  assign lo_nxt   = (wr_en && wr_addr == REG_LO)   ? wr_data : lo_pend;
  assign hi_nxt   = (wr_en && wr_addr == REG_HI)   ? wr_data : hi_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= PM_OFF;
      duty_pend <= '0;
      lo_pend   <= '0;
      hi_pend   <= '0;
    end else begin
      if (restart) mode_q <= mode_wr;
      duty_pend <= duty_nxt;
      lo_pend   <= lo_nxt;
      hi_pend   <= hi_nxt;
    end
  end

endmodule

// File: rtl/pwm_frame.sv
module pwm_frame #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              run,
  input  logic [DUTY_W-1:0] duty_nxt,
  output logic [DUTY_W-1:0] duty_act,
  output logic              frame_end,
  output logic              std_lvl,
  output logic              fast_lvl
);

  logic [DUTY_W-1:0] cnt, acc;
  logic [DUTY_W:0]   sum;

  // step added per tick: duty below half, else its complement
  function automatic logic [DUTY_W-1:0] fast_step(input logic [DUTY_W-1:0] d);
    return d[DUTY_W-1] ? ~d : d;
  endfunction

  // a carry marks a pulse: high pulse below half, low pulse at or above
  function automatic logic fast_level(input logic [DUTY_W-1:0] d, input logic carry);
    return d[DUTY_W-1] ? ~carry : carry;
  endfunction

  function automatic logic std_level(input logic [DUTY_W-1:0] c, input logic [DUTY_W-1:0] d);
    return c < d;
  endfunction

  assign sum       = {1'b0, acc} + {1'b0, fast_step(duty_act)};
  assign frame_end = run && (cnt == '1);
  assign std_lvl   = std_level(cnt, duty_act);
  assign fast_lvl  = fast_level(duty_act, sum[DUTY_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      acc      <= '0;
      duty_act <= '0;
    end else if (restart) begin
      cnt      <= '0;
      acc      <= '0;
      duty_act <= duty_nxt;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      if (frame_end) begin
        acc      <= '0;
        duty_act <= duty_nxt;
      end else begin
        acc <= sum[DUTY_W-1:0];
      end
    end
  end

endmodule

// File: rtl/pwm_varfreq.sv
module pwm_varfreq #(
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [PER_W-1:0] lo_nxt,
  input  logic [PER_W-1:0] hi_nxt,
  output logic [PER_W-1:0] lo_act,
  output logic [PER_W-1:0] hi_act,
  output logic             period_end,
  output logic             var_lvl
);

  logic [PER_W-1:0] cnt, limit;
  logic             phase;   // 0 low phase, 1 high phase
  logic             phase_end;

  assign limit      = phase ? hi_act : lo_act;
  assign phase_end  = run && (cnt == limit);
  assign period_end = phase_end && phase;
  assign var_lvl    = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      phase  <= 1'b0;
      lo_act <= '0;
      hi_act <= '0;
    end else if (restart) begin
      cnt    <= '0;
      phase  <= 1'b0;
      lo_act <= lo_nxt;
      hi_act <= hi_nxt;
    end else if (run) begin
      if (phase_end) begin
        cnt   <= '0;
        phase <= ~phase;
        if (phase) begin
          lo_act <= lo_nxt;
          hi_act <= hi_nxt;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int PER_W  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [PER_W-1:0] wr_data,
  output logic             pwm_out
);

  pwm_mode_e         mode_q;
  logic              restart;
  logic [DUTY_W-1:0] duty_nxt, duty_act;
  logic [PER_W-1:0]  lo_nxt, hi_nxt, lo_act, hi_act;
  logic              frame_end, var_period_end;
  logic              std_lvl, fast_lvl, var_lvl;
  logic              frame_run, var_run;

  assign frame_run = (mode_q == PM_STD) || (mode_q == PM_FAST);
  assign var_run   = (mode_q == PM_VAR);

  pwm_regs #(.DUTY_W(DUTY_W), .PER_W(PER_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .restart(restart),
    .duty_nxt(duty_nxt), .lo_nxt(lo_nxt), .hi_nxt(hi_nxt)
  );

  pwm_frame #(.DUTY_W(DUTY_W)) i_frame (
    .clk(clk), .rst(rst), .restart(restart), .run(frame_run),
    .duty_nxt(duty_nxt), .duty_act(duty_act), .frame_end(frame_end),
    .std_lvl(std_lvl), .fast_lvl(fast_lvl)
  );

  pwm_varfreq #(.PER_W(PER_W)) i_var (
    .clk(clk), .rst(rst), .restart(restart), .run(var_run),
    .lo_nxt(lo_nxt), .hi_nxt(hi_nxt), .lo_act(lo_act), .hi_act(hi_act),
    .period_end(var_period_end), .var_lvl(var_lvl)
  );

  always_comb begin
    unique case (mode_q)
      PM_STD:  pwm_out = std_lvl;
      PM_FAST: pwm_out = fast_lvl;
      PM_VAR:  pwm_out = var_lvl;
      default: pwm_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk
  import pwm_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int PER_W  = 13
) (
  input logic              clk,
  input logic              rst,
  input pwm_mode_e         mode_q,
  input logic              restart,
  input logic [1:0]        new_mode,
  input logic              frame_end,
  input logic              var_period_end,
  input logic [DUTY_W-1:0] duty_act,
  input logic [PER_W-1:0]  lo_act,
  input logic [PER_W-1:0]  hi_act,
  input logic              pwm_out
);

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !pwm_out);

  // R2
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_OFF) |-> !pwm_out);

  // R5
  fast_hi_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_FAST && !duty_act[DUTY_W-1] && pwm_out && !restart && !frame_end) |=> !pwm_out);

  // R6
  fast_lo_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_FAST && duty_act[DUTY_W-1] && !pwm_out && !restart && !frame_end) |=> pwm_out);

  // R8
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_end && !restart) |=> $stable(duty_act));

  // R9
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!var_period_end && !restart) |=> ($stable(lo_act) && $stable(hi_act)));

  // R10
  restart_low_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && (new_mode == PM_VAR || new_mode == PM_OFF)) |=> !pwm_out);

endmodule

bind pwm_channel pwm_channel_chk #(.DUTY_W(DUTY_W), .PER_W(PER_W)) i_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .restart(restart), .new_mode(wr_data[1:0]),
  .frame_end(frame_end), .var_period_end(var_period_end), .duty_act(duty_act),
  .lo_act(lo_act), .hi_act(hi_act), .pwm_out(pwm_out)
);

// File: tb/test_pwm_channel.sv
module test_pwm_channel;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [12:0] wr_data;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_MODE = 2'd0, A_DUTY = 2'd1, A_LO = 2'd2, A_HI = 2'd3;

  pwm_channel i_pwm_channel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge: drives for one cycle, returns one cycle later
  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = d[12:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (pwm_out == lvl && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h, n, mism, adj;
    logic prev;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);
    rst = 1'b0;
    @(negedge clk);
    count_high(20, h);
    chk(h == 0, "R1 idle after reset", h, 0);

    // R1: pending duty cleared by reset
    wr(A_MODE, 1);
    count_high(256, h);
    chk(h == 0, "R1 cleared duty", h, 0);
    wr(A_MODE, 0);

    // R2: off mode ignores value writes
    wr(A_DUTY, 200); wr(A_LO, 3); wr(A_HI, 3);
    count_high(30, h);
    chk(h == 0, "R2 off ignores writes", h, 0);

    // R4 / R3: standard mode sweep
    for (int d = 0; d < 256; d++) begin
      if (d % 17 == 0 || d <= 2 || d == 127 || d == 128 || d == 254 || d == 255) begin
        wr(A_DUTY, d); wr(A_MODE, 1);
        mism = 0; h = 0;
        for (int k = 0; k < 256; k++) begin
          if (pwm_out != (k < d)) mism++;
          if (pwm_out) h++;
          @(negedge clk);
        end
        chk(h == d, "R4 std high count", h, d);
        chk(mism == 0, "R4 std high first", mism, 0);
        wr(A_MODE, 0);
      end
    end

    // R5 / R6: fast mode exhaustive sweep
    for (int d = 0; d < 256; d++) begin
      wr(A_DUTY, d); wr(A_MODE, 2);
      h = 0; adj = 0; prev = pwm_out;
      for (int k = 0; k < 256; k++) begin
        if (pwm_out) h++;
        if (k > 0 && d < 128 && prev && pwm_out) adj++;
        if (k > 0 && d >= 128 && !prev && !pwm_out) adj++;
        prev = pwm_out;
        @(negedge clk);
      end
      if (d < 128) begin
        chk(h == d, "R5 fast high pulses", h, d);
        chk(d == 0 || adj == 0, "R5 fast pulses isolated", adj, 0);
      end else begin
        chk(h == d + 1, "R6 fast low pulses", h, d + 1);
        chk(d == 255 || adj == 0, "R6 fast gaps isolated", adj, 0);
      end
      wr(A_MODE, 0);
    end

    // R8: duty change mid-frame deferred
    wr(A_DUTY, 64); wr(A_MODE, 1);
    repeat (100) @(negedge clk);
    wr(A_DUTY, 200);                 // written in tick 100
    count_high(155, h);
    chk(h == 0, "R8 no mid-frame change", h, 0);
    count_high(255, h);
    chk(h == 200, "R8 new duty next frame", h, 200);
    wr(A_DUTY, 10);                  // written in the last tick of the frame
    count_high(256, h);
    chk(h == 10, "R8 last-tick write", h, 10);

    // R11: same-mode write does not restart
    wr(A_MODE, 0); wr(A_DUTY, 128); wr(A_MODE, 1);
    repeat (50) @(negedge clk);
    wr(A_MODE, 1);
    count_high(205, h);
    chk(h == 77, "R11 same mode no restart", h, 77);

    // R10: mid-frame switch to variable frequency starts low
    wr(A_LO, 4); wr(A_HI, 6);
    repeat (58) @(negedge clk);
    chk(pwm_out == 1'b1, "R10 pre-switch high", pwm_out, 1);
    wr(A_MODE, 3);
    run_len(1'b0, n); chk(n == 5, "R10 low phase first", n, 5);
    run_len(1'b1, n); chk(n == 7, "R7 high phase", n, 7);
    run_len(1'b0, n); chk(n == 5, "R7 low phase repeat", n, 5);

    // R7: variable frequency corner sweep
    for (int i = 0; i < 8; i++) begin
      int lo, hi;
      case (i)
        0: begin lo = 0;    hi = 0;    end
        1: begin lo = 1;    hi = 0;    end
        2: begin lo = 0;    hi = 1;    end
        3: begin lo = 3;    hi = 5;    end
        4: begin lo = 8191; hi = 8191; end
        5: begin lo = 0;    hi = 8191; end
        6: begin lo = 8191; hi = 0;    end
        default: begin lo = 100; hi = 37; end
      endcase
      wr(A_MODE, 0); wr(A_LO, lo); wr(A_HI, hi); wr(A_MODE, 3);
      run_len(1'b0, n); chk(n == lo + 1, "R7 low length", n, lo + 1);
      run_len(1'b1, n); chk(n == hi + 1, "R7 high length", n, hi + 1);
      run_len(1'b0, n); chk(n == lo + 1, "R7 low again", n, lo + 1);
    end

    // R9: period writes during high phase deferred
    wr(A_MODE, 0); wr(A_LO, 2); wr(A_HI, 4); wr(A_MODE, 3);
    run_len(1'b0, n); chk(n == 3, "R9 low before", n, 3);
    wr(A_LO, 1); wr(A_HI, 9);
    run_len(1'b1, n); chk(n == 3, "R9 high kept", n, 3);
    run_len(1'b0, n); chk(n == 2, "R9 new low", n, 2);
    run_len(1'b1, n); chk(n == 10, "R9 new high", n, 10);

    // R2: back to off, output low despite writes
    wr(A_MODE, 0);
    wr(A_DUTY, 255); wr(A_HI, 0); wr(A_LO, 0);
    count_high(50, h);
    chk(h == 0, "R2 off stays low", h, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule